// File: doc/BRIEF.md
# Safeload Parameter Transfer Engine

This block stages coefficient updates for a parameter RAM so that they land between audio frames and never while a frame is being processed. Software writes address/data pairs into a small bank of staging entries over a control bus; each write marks its entry as pending. When software requests a transfer, the engine waits for the next frame-boundary strobe. It then copies every pending entry into the parameter RAM, one write per clock, and skips the entries that were not touched.

While a transfer is waiting or copying, the engine reports busy and refuses new staging writes. A writer that meets busy keeps its write asserted until the write is accepted. Completion shows up on a done flag that software polls. The flag drops when a new request is accepted and rises once the last pending entry has been copied. The parameter RAM sits outside the block, and only its write port is driven from here.

Top module: `safeload_engine`

## Requirements
- R1: After reset the engine is idle: done_o, stg_busy_o and ram_we_o are 0, and no staging entry is pending.
- R2: A staging write accepted while stg_busy_o is 0 stores the address and data into entry stg_idx_i and marks that entry pending. An index of NUM_ENTRIES or above is ignored and changes no entry.
- R3: stg_busy_o is 1 from the cycle after a request is accepted until the transfer finishes. A staging write presented while busy is not accepted, and it takes effect only at the first clock edge at which busy is 0.
- R4: A request is accepted only while stg_busy_o is 0. Acceptance clears done_o and raises stg_busy_o in the next cycle. A request made while busy is ignored.
- R5: Copying begins only on a frame strobe seen after the request has been accepted. A strobe in the same cycle as the request does not count. The first RAM write appears in the cycle after the strobe edge.
- R6: Only pending entries are written to the RAM. They go out in ascending index order, one per clock in consecutive cycles, with ram_addr_o and ram_data_o carrying the entry's stored pair.
- R7: An entry's pending flag clears when that entry is written to the RAM, so a later transfer skips it unless it has been written again.
- R8: done_o rises and stg_busy_o falls in the cycle after the last RAM write of a transfer. The two are never 1 together.
- R9: A request with no pending entries completes on the next frame strobe, with done_o rising in the cycle after the strobe edge and no RAM write.
- R10: Writing the same entry twice before a transfer produces a single RAM write that carries the later pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stg_we_i | input | 1 | Staging write request, held until accepted |
| stg_idx_i | input | IDX_W | Staging entry index |
| stg_addr_i | input | ADDR_W | Parameter RAM address to stage |
| stg_data_i | input | DATA_W | Parameter data to stage |
| stg_busy_o | output | 1 | Transfer pending or active; staging writes held off |
| xfer_req_i | input | 1 | Transfer request pulse |
| frame_strobe_i | input | 1 | Frame-boundary strobe |
| ram_we_o | output | 1 | Parameter RAM write enable |
| ram_addr_o | output | ADDR_W | Parameter RAM write address |
| ram_data_o | output | DATA_W | Parameter RAM write data |
| done_o | output | 1 | Transfer complete, pollable |

## Verification
The bench drives a table of pending-entry masks, including the empty-adjacent single entries, the full bank and alternating patterns. An engine that copied clean entries, copied them out of order or left gaps between writes would show wrong addresses or wrong cycle stamps in the RAM write log. Directed cases place a strobe in the same cycle as the request, which catches an engine that starts copying too early. They also hold a staging write through a whole transfer, which catches one that lets the write through while busy or drops it afterwards. Further cases cover an out-of-range index, a double write to one entry and a request with nothing pending. These expose a corrupted bank, a duplicate RAM write and a done flag that never rises.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_ARMED = 2'd1,
    SL_COPY  = 2'd2
  } sl_state_e;
endpackage

// File: rtl/safeload_stage.sv
module safeload_stage #(
  parameter int NUM_ENTRIES = 5,
  parameter int IDX_W       = 3,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 26
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          clr_en_i,
  input  logic [IDX_W-1:0]              clr_idx_i,
  output logic [NUM_ENTRIES-1:0]        dirty_o,
  output logic [NUM_ENTRIES*ADDR_W-1:0] addr_o,
  output logic [NUM_ENTRIES*DATA_W-1:0] data_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              dirty_q;
    logic              hit_wr, hit_clr;

    assign hit_wr  = wr_en_i  && (wr_idx_i  == IDX_W'(g));
    assign hit_clr = clr_en_i && (clr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q  <= '0;
        data_q  <= '0;
        dirty_q <= 1'b0;
      end else if (hit_wr) begin
        addr_q  <= wr_addr_i;
        data_q  <= wr_data_i;
        dirty_q <= 1'b1;
      end else if (hit_clr) begin
        dirty_q <= 1'b0;
      end
    end

    assign dirty_o[g]                   = dirty_q;
    assign addr_o[g*ADDR_W +: ADDR_W]   = addr_q;
    assign data_o[g*DATA_W +: DATA_W]   = data_q;
  end
endmodule

// File: rtl/safeload_pick.sv
module safeload_pick #(
  parameter int NUM_ENTRIES = 5,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_ENTRIES-1:0] dirty_i,
  output logic                   any_o,
  output logic                   last_o,
  output logic [IDX_W-1:0]       idx_o
);
  // lowest pending index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (dirty_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o  = |dirty_i;
  assign last_o = ($countones(dirty_i) == 1);
endmodule

// File: rtl/safeload_ctrl.sv
module safeload_ctrl
  import safeload_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic strobe_i,
  input  logic any_i,
  input  logic last_i,
  output logic clr_en_o,
  output logic busy_o,
  output logic done_o
);
  sl_state_e state_q;
  logic      done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SL_IDLE;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SL_IDLE: if (req_i) begin
          state_q <= SL_ARMED;
          done_q  <= 1'b0;
        end
        SL_ARMED: if (strobe_i) begin
          if (any_i) begin
            state_q <= SL_COPY;
          end else begin
            state_q <= SL_IDLE;
            done_q  <= 1'b1;
          end
        end
        SL_COPY: if (last_i || !any_i) begin
          state_q <= SL_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= SL_IDLE;
      endcase
    end
  end

  assign clr_en_o = (state_q == SL_COPY) && any_i;
  assign busy_o   = (state_q != SL_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/safeload_engine.sv
module safeload_engine #(
  parameter int NUM_ENTRIES = 5,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 26,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stg_we_i,
  input  logic [IDX_W-1:0]  stg_idx_i,
  input  logic [ADDR_W-1:0] stg_addr_i,
  input  logic [DATA_W-1:0] stg_data_i,
  output logic              stg_busy_o,
  input  logic              xfer_req_i,
  input  logic              frame_strobe_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              done_o
);
  logic [NUM_ENTRIES-1:0]        dirty;
  logic [NUM_ENTRIES*ADDR_W-1:0] addr_flat;
  logic [NUM_ENTRIES*DATA_W-1:0] data_flat;
  logic [IDX_W-1:0]              sel_idx;
  logic                          any_dirty, last_dirty, clr_en, busy, wr_accept;

  assign wr_accept = stg_we_i && !busy;

  safeload_stage #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_accept),
    .wr_idx_i (stg_idx_i),
    .wr_addr_i(stg_addr_i),
    .wr_data_i(stg_data_i),
    .clr_en_i (clr_en),
    .clr_idx_i(sel_idx),
    .dirty_o  (dirty),
    .addr_o   (addr_flat),
    .data_o   (data_flat)
  );

  safeload_pick #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .dirty_i(dirty),
    .any_o  (any_dirty),
    .last_o (last_dirty),
    .idx_o  (sel_idx)
  );

  safeload_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (xfer_req_i),
    .strobe_i(frame_strobe_i),
    .any_i   (any_dirty),
    .last_i  (last_dirty),
    .clr_en_o(clr_en),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  assign stg_busy_o = busy;
  assign ram_we_o   = clr_en;
  assign ram_addr_o = addr_flat[int'(sel_idx)*ADDR_W +: ADDR_W];
  assign ram_data_o = data_flat[int'(sel_idx)*DATA_W +: DATA_W];
endmodule

// File: rtl/safeload_engine_chk.sv
module safeload_engine_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xfer_req_i,
  input logic             frame_strobe_i,
  input logic             busy_i,
  input logic             ram_we_i,
  input logic             done_i,
  input logic [IDX_W-1:0] sel_idx_i
);
  // R4
  req_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_i && !busy_i |=> busy_i && !done_i);

  // R3
  busy_only_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !xfer_req_i |=> !busy_i);

  // R5
  copy_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_i) |-> $past(frame_strobe_i));

  // R6
  ascending_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_i && $past(ram_we_i) |-> sel_idx_i > $past(sel_idx_i));

  // R6
  write_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_i |-> busy_i);

  // R8
  done_on_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $fell(busy_i));

  // R8
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && busy_i));
endmodule

bind safeload_engine safeload_engine_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .xfer_req_i    (xfer_req_i),
  .frame_strobe_i(frame_strobe_i),
  .busy_i        (stg_busy_o),
  .ram_we_i      (ram_we_o),
  .done_i        (done_o),
  .sel_idx_i     (sel_idx)
);

// File: tb/safeload_engine_tb.sv
module safeload_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int IW = 3;
  localparam int AW = 10;
  localparam int DW = 26;
  localparam int NVEC = 8;
  localparam logic [N-1:0] MASKS [NVEC] = '{
    5'b00001, 5'b10000, 5'b11111, 5'b01010,
    5'b10101, 5'b00110, 5'b11000, 5'b01101
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stg_we = 1'b0, xfer_req = 1'b0, strobe = 1'b0;
  logic [IW-1:0] stg_idx = '0;
  logic [AW-1:0] stg_addr = '0;
  logic [DW-1:0] stg_data = '0;
  logic busy, ram_we, done;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_data;

  int checks = 0, errors = 0;
  int cyc = 0;
  int log_n = 0;
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int            log_cyc  [64];
  logic [AW-1:0] exp_addr [N];
  logic [DW-1:0] exp_data [N];
  int exp_n, base, sc;
  bit finished = 1'b0;

  safeload_engine #(.NUM_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .stg_we_i(stg_we), .stg_idx_i(stg_idx), .stg_addr_i(stg_addr), .stg_data_i(stg_data),
    .stg_busy_o(busy), .xfer_req_i(xfer_req), .frame_strobe_i(strobe),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_data_o(ram_data), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // RAM write log, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_ni && ram_we && log_n < 64) begin
      log_addr[log_n] = ram_addr;
      log_data[log_n] = ram_data;
      log_cyc[log_n]  = cyc;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic stage_write(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    stg_we = 1'b1; stg_idx = IW'(idx); stg_addr = a; stg_data = d;
    @(negedge clk);
    stg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic req_phase(input string tag);
    base = log_n;
    pulse_req();
    check(busy === 1'b1, "R4", {tag, " busy after request"}, busy, 1);
    check(done === 1'b0, "R4", {tag, " done cleared"}, done, 0);
    repeat (2) @(negedge clk);
    check(log_n == base, "R5", {tag, " no write before strobe"}, log_n - base, 0);
  endtask

  task automatic finish_phase(input string tag);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    sc = cyc;
    repeat (exp_n) @(negedge clk);
    check(done === 1'b1, "R8", {tag, " done after last write"}, done, 1);
    check(busy === 1'b0, "R8", {tag, " busy dropped"}, busy, 0);
    check(log_n - base == exp_n, "R6", {tag, " write count"}, log_n - base, exp_n);
    for (int j = 0; j < exp_n && base + j < log_n; j++) begin
      check(log_addr[base+j] == exp_addr[j], "R6", {tag, " addr"}, log_addr[base+j], exp_addr[j]);
      check(log_data[base+j] == exp_data[j], "R6", {tag, " data"}, log_data[base+j], exp_data[j]);
      check(log_cyc[base+j] == sc + j, "R5", {tag, " write cycle"}, log_cyc[base+j], sc + j);
    end
  endtask

  function automatic logic [AW-1:0] va(input int v, input int i);
    return AW'(v * 37 + i * 5 + 3);
  endfunction
  function automatic logic [DW-1:0] vd(input int v, input int i);
    return DW'(32'h0155_AA00 + v * 4099 + i * 131);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done === 1'b0, "R1", "done in reset", done, 0);
    check(busy === 1'b0, "R1", "busy in reset", busy, 0);
    check(ram_we === 1'b0, "R1", "ram_we in reset", ram_we, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1/R9: nothing pending after reset, empty transfer
    exp_n = 0;
    req_phase("r1_empty");
    finish_phase("r9_after_reset");

    // R2: out-of-range index ignored
    stage_write(6, 10'h155, 26'h123);
    stage_write(7, 10'h0AA, 26'h456);
    exp_n = 0;
    req_phase("r2_oob");
    finish_phase("r2_oob");

    // Vector table: R6, R7
    for (int v = 0; v < NVEC; v++) begin
      exp_n = 0;
      for (int i = 0; i < N; i++) begin
        if (MASKS[v][i]) begin
          stage_write(i, va(v, i), vd(v, i));
          exp_addr[exp_n] = va(v, i);
          exp_data[exp_n] = vd(v, i);
          exp_n++;
        end
      end
      req_phase("r6_vec");
      finish_phase("r6_vec");
    end

    // R7: flags cleared, nothing rewritten
    exp_n = 0;
    req_phase("r7_clean");
    finish_phase("r7_clean");

    // R10: double write keeps latest pair
    stage_write(3, 10'h011, 26'h000_0111);
    stage_write(3, 10'h222, 26'h222_2222);
    exp_n = 1; exp_addr[0] = 10'h222; exp_data[0] = 26'h222_2222;
    req_phase("r10_overwrite");
    finish_phase("r10_overwrite");

    // R3: write held while busy
    stage_write(2, 10'h0C2, 26'h0C2_C2C2);
    exp_n = 1; exp_addr[0] = 10'h0C2; exp_data[0] = 26'h0C2_C2C2;
    req_phase("r3_hold");
    stg_we = 1'b1; stg_idx = 3'd0; stg_addr = 10'h3F0; stg_data = 26'h3F0_0F0F;
    repeat (2) @(negedge clk);
    check(busy === 1'b1, "R3", "busy holds off write", busy, 1);
    finish_phase("r3_hold");
    @(negedge clk);
    stg_we = 1'b0;
    exp_n = 1; exp_addr[0] = 10'h3F0; exp_data[0] = 26'h3F0_0F0F;
    req_phase("r3_late");
    finish_phase("r3_late");

    // R5: strobe in the same cycle as the request is not counted
    stage_write(4, 10'h144, 26'h144_4444);
    base = log_n;
    @(negedge clk); xfer_req = 1'b1; strobe = 1'b1;
    @(negedge clk); xfer_req = 1'b0; strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(log_n == base, "R5", "same-cycle strobe ignored", log_n - base, 0);
    check(busy === 1'b1, "R5", "still waiting", busy, 1);
    // R4: request while busy ignored
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    exp_n = 1; exp_addr[0] = 10'h144; exp_data[0] = 26'h144_4444;
    finish_phase("r5_same");
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R4", "request while busy not queued", busy, 0);
    check(done === 1'b1, "R4", "done stays set", done, 1);

    finish_run();
  end
endmodule